// File: doc/BRIEF.md
# SMBus Block Transfer Buffer

This block is the byte store that an SMBus host controller uses for block transfers. Software reaches the store through a single block-data port, and an internal index steps through it. Before a block write, software loads the byte count into the count register and then pushes the payload through the port. During the write, the bus engine pops the bytes back out in order. On a block read, the process runs the other way. The engine loads the count it received from the target and pushes the payload in. Software then drains the payload through the port.

The store only takes part in a transfer when the enable bit in the auxiliary control register is set and the host is running an SMBus block protocol. Under an I2C block protocol the store is bypassed. Reading the control register has a side effect: it rewinds the software index to the first entry. The engine keeps its own index, and this index rewinds when a transaction starts. A count received from the target is checked against the capacity of the store. The bus engine itself is outside this block.

Top module: `smbus_blkbuf`

## Requirements
- R1: After reset, `aux_o`, `count_o`, `cnt_err_o`, `blk_rdata_o` and `eng_pop_data_o` are all zero, and both indexes and all 32 entries are zero.
- R2: A write to auxiliary control keeps only bit 1, the enable bit. That bit reads back as written, and every other bit of `aux_o` reads 0.
- R3: When the store is active, each port write stores `blk_wdata_i` at the software index and then advances the index by one. Each port read advances the index by one. `blk_rdata_o` always shows the entry at the software index.
- R4: A `ctl_rd_i` pulse sets the software index to 0 on the next clock edge, whatever else happens in that cycle.
- R5: Each index saturates at entry 31. A further advance leaves it at 31, so repeated writes overwrite entry 31 and repeated reads return entry 31.
- R6: `count_o` takes `cnt_wdata_i` on a software count write and `eng_cnt_i` on an engine count load. If both happen in the same cycle, the engine load wins.
- R7: An engine count load of 0, or of more than 32, sets `cnt_err_o`. An engine load in the range 1..32 clears it, and so does a software count write.
- R8: `eng_start_i` sets the engine index to 0. Each pop advances the engine index, and `eng_pop_data_o` shows the entry at the engine index, so a block write is drained from entry 0 in the order it was stored.
- R9: Each engine push stores `eng_push_data_i` at the engine index and advances it, so software reads the payload back in the order it arrived.
- R10: The store is active only when the enable bit is 1 and `i2c_mode_i` is 0. While it is inactive, port and engine accesses neither store data nor move an index, and both data outputs read 0.
- R11: If an engine push and a port write fall in the same cycle, the engine byte is stored. The port write is dropped and the software index does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| i2c_mode_i | input | 1 | Host is running an I2C block protocol, so the store is bypassed |
| ctl_rd_i | input | 1 | Strobe for a host control register read; rewinds the software index |
| aux_wr_i | input | 1 | Write strobe for auxiliary control |
| aux_wdata_i | input | 8 | Auxiliary control write data (bit 1 is the enable) |
| aux_o | output | 8 | Auxiliary control readback |
| cnt_wr_i | input | 1 | Software write strobe for the count register |
| cnt_wdata_i | input | 8 | Software count value |
| count_o | output | 8 | Count register |
| blk_wr_i | input | 1 | Block-data port write strobe |
| blk_wdata_i | input | 8 | Block-data port write byte |
| blk_rd_i | input | 1 | Block-data port read strobe; advances the index |
| blk_rdata_o | output | 8 | Entry at the software index |
| eng_start_i | input | 1 | Transaction start; rewinds the engine index |
| eng_pop_i | input | 1 | Engine consumes the current byte |
| eng_pop_data_o | output | 8 | Entry at the engine index |
| eng_push_i | input | 1 | Engine stores a received byte |
| eng_push_data_i | input | 8 | Received byte |
| eng_cnt_wr_i | input | 1 | Engine loads the received count |
| eng_cnt_i | input | 8 | Received count |
| cnt_err_o | output | 1 | Received count outside 1..32 |

## Verification
The bench builds the block with its default parameters: 32 entries of 8 bits, and the enable in bit 1. With these values, 34 consecutive port writes drive the software index into saturation and then overwrite the last entry. The engine count boundary values 0, 32 and 33 fall on both sides of the capacity limit. Both routes to an inactive store are covered: a cleared enable bit and I2C mode. A same-cycle collision between a push and a port write is also covered.

// File: rtl/smbb_pkg.sv
package smbb_pkg;
  parameter int unsigned SMBB_DEPTH  = 32;
  parameter int unsigned SMBB_DW     = 8;
  parameter int unsigned SMBB_EN_BIT = 1;
endpackage

// File: rtl/smbb_ptr.sv
module smbb_ptr #(
  parameter int unsigned DEPTH = smbb_pkg::SMBB_DEPTH,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  output logic [IW-1:0] idx_o
);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  logic [IW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       idx_q <= '0;
    else if (clr_i)                    idx_q <= '0;
    else if (adv_i && idx_q != LAST)   idx_q <= idx_q + 1'b1;
  end

  assign idx_o = idx_q;

  a_r4_rewind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> idx_o == '0);
  a_r5_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !clr_i && idx_o == LAST) |=> idx_o == LAST);
endmodule

// File: rtl/smbb_store.sv
module smbb_store #(
  parameter int unsigned DEPTH = smbb_pkg::SMBB_DEPTH,
  parameter int unsigned DW    = smbb_pkg::SMBB_DW,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [IW-1:0] raddr_a_i,
  output logic [DW-1:0] rdata_a_o,
  input  logic [IW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_b_o
);
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mem_q[g] <= '0;
      else if (we_i && waddr_i == IW'(g))      mem_q[g] <= wdata_i;
    end
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/smbb_regs.sv
module smbb_regs #(
  parameter int unsigned DEPTH  = smbb_pkg::SMBB_DEPTH,
  parameter int unsigned DW     = smbb_pkg::SMBB_DW,
  parameter int unsigned EN_BIT = smbb_pkg::SMBB_EN_BIT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          aux_wr_i,
  input  logic [DW-1:0] aux_wdata_i,
  input  logic          cnt_wr_i,
  input  logic [DW-1:0] cnt_wdata_i,
  input  logic          eng_cnt_wr_i,
  input  logic [DW-1:0] eng_cnt_i,
  output logic [DW-1:0] aux_o,
  output logic          en_o,
  output logic [DW-1:0] count_o,
  output logic          err_o
);
  localparam logic [DW-1:0] MAX_CNT = DW'(DEPTH);

  logic          en_q;
  logic [DW-1:0] cnt_q;
  logic          err_q;
  logic          eng_bad;

  assign eng_bad = (eng_cnt_i == '0) || (eng_cnt_i > MAX_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_q <= 1'b0;
    else if (aux_wr_i) en_q <= aux_wdata_i[EN_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else if (eng_cnt_wr_i) begin
      cnt_q <= eng_cnt_i;
      err_q <= eng_bad;
    end else if (cnt_wr_i) begin
      cnt_q <= cnt_wdata_i;
      err_q <= 1'b0;
    end
  end

  always_comb begin
    aux_o         = '0;
    aux_o[EN_BIT] = en_q;
  end

  assign en_o    = en_q;
  assign count_o = cnt_q;
  assign err_o   = err_q;

  a_r7_flag_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_cnt_wr_i && eng_cnt_i == '0) |=> err_o);
  a_r7_clear_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_cnt_wr_i && eng_cnt_i != '0 && eng_cnt_i <= MAX_CNT) |=> !err_o);
  a_r6_sw_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_wr_i && !eng_cnt_wr_i) |=> count_o == $past(cnt_wdata_i));
endmodule

// File: rtl/smbus_blkbuf.sv
module smbus_blkbuf #(
  parameter int unsigned DEPTH  = smbb_pkg::SMBB_DEPTH,
  parameter int unsigned DW     = smbb_pkg::SMBB_DW,
  parameter int unsigned EN_BIT = smbb_pkg::SMBB_EN_BIT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          i2c_mode_i,
  input  logic          ctl_rd_i,
  input  logic          aux_wr_i,
  input  logic [DW-1:0] aux_wdata_i,
  output logic [DW-1:0] aux_o,
  input  logic          cnt_wr_i,
  input  logic [DW-1:0] cnt_wdata_i,
  output logic [DW-1:0] count_o,
  input  logic          blk_wr_i,
  input  logic [DW-1:0] blk_wdata_i,
  input  logic          blk_rd_i,
  output logic [DW-1:0] blk_rdata_o,
  input  logic          eng_start_i,
  input  logic          eng_pop_i,
  output logic [DW-1:0] eng_pop_data_o,
  input  logic          eng_push_i,
  input  logic [DW-1:0] eng_push_data_i,
  input  logic          eng_cnt_wr_i,
  input  logic [DW-1:0] eng_cnt_i,
  output logic          cnt_err_o
);
  localparam int unsigned IW = $clog2(DEPTH);

  logic          en, act;
  logic          sw_store, eng_store, sw_adv, eng_adv, we;
  logic [IW-1:0] sw_idx, eng_idx, waddr;
  logic [DW-1:0] wdata, rd_sw, rd_eng;

  smbb_regs #(.DEPTH(DEPTH), .DW(DW), .EN_BIT(EN_BIT)) u_regs (
    .clk_i, .rst_ni,
    .aux_wr_i, .aux_wdata_i,
    .cnt_wr_i, .cnt_wdata_i,
    .eng_cnt_wr_i, .eng_cnt_i,
    .aux_o, .en_o(en), .count_o, .err_o(cnt_err_o)
  );

  // store serves SMBus block protocols only
  assign act       = en && !i2c_mode_i;
  assign eng_store = act && eng_push_i;
  assign sw_store  = act && blk_wr_i && !eng_push_i;
  assign sw_adv    = act && (blk_rd_i || (blk_wr_i && !eng_push_i));
  assign eng_adv   = act && (eng_pop_i || eng_push_i);
  assign we        = eng_store || sw_store;
  assign waddr     = eng_store ? eng_idx : sw_idx;
  assign wdata     = eng_store ? eng_push_data_i : blk_wdata_i;

  smbb_ptr #(.DEPTH(DEPTH)) u_sw_ptr (
    .clk_i, .rst_ni, .clr_i(ctl_rd_i), .adv_i(sw_adv), .idx_o(sw_idx)
  );

  smbb_ptr #(.DEPTH(DEPTH)) u_eng_ptr (
    .clk_i, .rst_ni, .clr_i(eng_start_i), .adv_i(eng_adv), .idx_o(eng_idx)
  );

  smbb_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk_i, .rst_ni,
    .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_a_i(sw_idx), .rdata_a_o(rd_sw),
    .raddr_b_i(eng_idx), .rdata_b_o(rd_eng)
  );

  assign blk_rdata_o    = act ? rd_sw  : '0;
  assign eng_pop_data_o = act ? rd_eng : '0;

  a_r10_sw_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act && !ctl_rd_i) |=> $stable(sw_idx));
  a_r10_eng_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act && !eng_start_i) |=> $stable(eng_idx));
  a_r11_push_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_push_i && blk_wr_i && !blk_rd_i && !ctl_rd_i) |=> $stable(sw_idx));
  a_r10_quiet_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act |-> (blk_rdata_o == '0 && eng_pop_data_o == '0));
endmodule

// File: tb/smbus_blkbuf_test.sv
`timescale 1ns/1ps
module smbus_blkbuf_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       i2c = 0, ctl_rd = 0, aux_wr = 0, cnt_wr = 0, blk_wr = 0, blk_rd = 0;
  logic       e_start = 0, e_pop = 0, e_push = 0, e_cnt_wr = 0;
  logic [7:0] aux_d = 0, cnt_d = 0, blk_d = 0, push_d = 0, e_cnt = 0;
  logic [7:0] aux_o, count_o, blk_q, pop_q;
  logic       err_o;

  smbus_blkbuf uut (
    .clk_i(clk), .rst_ni(rst_n), .i2c_mode_i(i2c), .ctl_rd_i(ctl_rd),
    .aux_wr_i(aux_wr), .aux_wdata_i(aux_d), .aux_o(aux_o),
    .cnt_wr_i(cnt_wr), .cnt_wdata_i(cnt_d), .count_o(count_o),
    .blk_wr_i(blk_wr), .blk_wdata_i(blk_d), .blk_rd_i(blk_rd), .blk_rdata_o(blk_q),
    .eng_start_i(e_start), .eng_pop_i(e_pop), .eng_pop_data_o(pop_q),
    .eng_push_i(e_push), .eng_push_data_i(push_d),
    .eng_cnt_wr_i(e_cnt_wr), .eng_cnt_i(e_cnt), .cnt_err_o(err_o)
  );

  int checks = 0, failures = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [7:0] m_mem [32];
  int m_pidx, m_eidx, m_cnt;
  bit m_en, m_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 0;
      m_pidx = 0; m_eidx = 0; m_cnt = 0; m_en = 0; m_err = 0;
    end else begin
      bit a, padv, eadv;
      a    = m_en && !i2c;
      padv = a && (blk_rd || (blk_wr && !e_push));
      eadv = a && (e_pop || e_push);
      if (a && e_push)              m_mem[m_eidx] = push_d;
      else if (a && blk_wr)         m_mem[m_pidx] = blk_d;
      if (ctl_rd)                   m_pidx = 0;
      else if (padv && m_pidx < 31) m_pidx++;
      if (e_start)                  m_eidx = 0;
      else if (eadv && m_eidx < 31) m_eidx++;
      if (aux_wr) m_en = aux_d[1];
      if (e_cnt_wr) begin
        m_cnt = e_cnt; m_err = (e_cnt == 0) || (e_cnt > 32);
      end else if (cnt_wr) begin
        m_cnt = cnt_d; m_err = 0;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      bit a;
      a = m_en && !i2c;
      chk("R3 blk_rdata", blk_q, a ? m_mem[m_pidx] : 0);
      chk("R8 eng_pop_data", pop_q, a ? m_mem[m_eidx] : 0);
      chk("R2 aux", aux_o, m_en ? 8'h02 : 8'h00);
      chk("R6 count", count_o, m_cnt);
      chk("R7 err", err_o, m_err);
    end
  end

  task automatic tick();
    @(negedge clk);
    ctl_rd = 0; aux_wr = 0; cnt_wr = 0; blk_wr = 0; blk_rd = 0;
    e_start = 0; e_pop = 0; e_push = 0; e_cnt_wr = 0;
  endtask
  task automatic do_aux(logic [7:0] v);  aux_wr = 1; aux_d = v; tick(); endtask
  task automatic do_cnt(logic [7:0] v);  cnt_wr = 1; cnt_d = v; tick(); endtask
  task automatic do_ecnt(logic [7:0] v); e_cnt_wr = 1; e_cnt = v; tick(); endtask
  task automatic do_wr(logic [7:0] v);   blk_wr = 1; blk_d = v; tick(); endtask
  task automatic do_push(logic [7:0] v); e_push = 1; push_d = v; tick(); endtask
  task automatic do_rd();    blk_rd = 1; tick(); endtask
  task automatic do_ctl();   ctl_rd = 1; tick(); endtask
  task automatic do_start(); e_start = 1; tick(); endtask
  task automatic do_pop();   e_pop = 1; tick(); endtask

  bit done = 0;
  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 aux reset", aux_o, 0);
    chk("R1 count reset", count_o, 0);
    chk("R1 err reset", err_o, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rdata reset", blk_q, 0);
    chk("R1 pop reset", pop_q, 0);

    do_aux(8'hFF); chk("R2 only enable bit", aux_o, 8'h02);
    do_aux(8'hFD); chk("R2 enable cleared", aux_o, 8'h00);
    do_aux(8'h02);

    do_cnt(8'd5); chk("R6 sw count", count_o, 5);
    for (int i = 0; i < 5; i++) do_wr(8'h11 + 8'(i));
    do_ctl(); chk("R4 rewind first byte", blk_q, 8'h11);
    for (int i = 0; i < 5; i++) begin
      chk("R3 read order", blk_q, 8'h11 + i);
      do_rd();
    end

    do_start(); chk("R8 pop from zero", pop_q, 8'h11);
    for (int i = 0; i < 5; i++) begin
      chk("R8 pop order", pop_q, 8'h11 + i);
      do_pop();
    end

    do_ctl();
    for (int i = 0; i < 34; i++) do_wr(8'h40 + 8'(i));
    do_ctl();
    for (int i = 0; i < 31; i++) do_rd();
    chk("R5 last entry overwritten", blk_q, 8'h61);
    do_rd(); do_rd();
    chk("R5 index held at 31", blk_q, 8'h61);

    do_start();
    do_ecnt(8'd3); chk("R7 valid count", err_o, 0);
    chk("R6 engine count", count_o, 3);
    do_push(8'hA1); do_push(8'hA2); do_push(8'hA3);
    do_ctl(); chk("R9 first pushed byte", blk_q, 8'hA1);
    do_rd();  chk("R9 second pushed byte", blk_q, 8'hA2);
    do_ctl();

    do_ecnt(8'd0);  chk("R7 zero count", err_o, 1);
    do_ecnt(8'd32); chk("R7 count 32 ok", err_o, 0);
    do_ecnt(8'd33); chk("R7 count 33", err_o, 1);
    do_cnt(8'd4);   chk("R7 sw write clears", err_o, 0);
    cnt_wr = 1; cnt_d = 8'd9; e_cnt_wr = 1; e_cnt = 8'd7; tick();
    chk("R6 engine load wins", count_o, 7);

    i2c = 1;
    do_wr(8'h77); do_push(8'h66);
    chk("R10 i2c mode reads zero", blk_q, 0);
    i2c = 0;
    @(negedge clk);
    chk("R10 i2c mode no store", blk_q, 8'hA1);
    chk("R10 i2c mode engine held", pop_q, 8'h43);
    do_aux(8'h00);
    do_wr(8'h78); do_push(8'h67); do_rd(); do_pop();
    chk("R10 disabled reads zero", blk_q, 0);
    do_aux(8'h02);
    chk("R10 disabled no store", blk_q, 8'hA1);
    chk("R10 disabled engine held", pop_q, 8'h43);

    do_start();
    blk_wr = 1; blk_d = 8'hC0; e_push = 1; push_d = 8'hB0; tick();
    chk("R11 push stored, index held", blk_q, 8'hB0);
    do_wr(8'hC1);
    chk("R11 index advanced after", blk_q, 8'hA2);
    do_ctl();
    chk("R11 port write lands at entry 0", blk_q, 8'hC1);

    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule